// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block paces the retries of a contended atomic read-modify-write. A requester pulses `op_start` when it begins a new operation. Each time its compare-and-swap loses, it pulses `op_fail`. When the operation finally goes through, it pulses `op_success`. For every accepted failure the controller raises a wait request. The request carries one cycle count, which a pause unit downstream consumes in a single piece. When that unit answers with `wait_done`, the controller pulses `retry_go` to let the requester try again.

The wait length grows exponentially. A backoff register starts at one for every new operation. Each accepted failure requests that value times 128 cycles, and then doubles the register. The register stops doubling once it has passed the limit, so it settles one step above it.

A build parameter selects a single-strand variant. That variant never asks for a wait: it lets the retry go at once.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset the block is idle, `wait_req` and `retry_go` are 0 and `backoff_val` is 1.
- R2: An `op_start` pulse loads `backoff_val` with 1 on the next cycle, from any state. It also withdraws any outstanding wait request, and `op_start` has priority over every other input in the same cycle.
- R3: A `op_fail` accepted while an operation is active sets `wait_req` on the next cycle. At the same time `wait_cycles` becomes the backoff value held before that failure, shifted left by 7 bits (value times 128, bit 7 upward). The request and its count then hold steady until `wait_done`.
- R4: An accepted failure doubles `backoff_val` (left shift by one) when the value is not greater than 4096.
- R5: When `backoff_val` is above 4096 an accepted failure leaves it unchanged, so it never exceeds 8192 and the largest count is 1048576.
- R6: `wait_done` during an outstanding wait clears `wait_req` on the next cycle and pulses `retry_go` high for exactly one cycle. The block is then ready for another failure.
- R7: `op_fail` pulses that arrive while a wait is outstanding change neither `backoff_val`, `wait_req` nor `wait_cycles`.
- R8: `op_success` while active returns the block to idle. `op_fail` in idle raises no wait and leaves `backoff_val` unchanged.
- R9: With the single-strand option set, an accepted failure pulses `retry_go` on the next cycle, `wait_req` never rises and `backoff_val` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Begin a new atomic operation |
| op_fail | input | 1 | The compare-and-swap attempt failed |
| op_success | input | 1 | The operation completed |
| wait_done | input | 1 | The requested wait has elapsed |
| wait_req | output | 1 | Wait request, held until `wait_done` |
| wait_cycles | output | 21 | Cycle count of the requested wait |
| retry_go | output | 1 | One-cycle permission to retry |
| backoff_val | output | 14 | Current backoff value |

## Verification
The bench builds two copies from the same stimulus. One uses the default widths with a limit of 4096 and backoff enabled. Fifteen back-to-back failures carry it through every doubling, past the limit and into saturation at 8192, and a reference model predicts each count. The second copy sets the single-strand option, which brings the immediate-retry path within reach.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WAIT   = 2'd2
    } bo_state_e;

    localparam int DEF_BO_W     = 14;
    localparam int DEF_SCALE_SH = 7;
    localparam int DEF_LIMIT    = 4096;

    // Wait length in cycles for a given backoff value
    function automatic logic [DEF_BO_W+DEF_SCALE_SH-1:0] scale_wait(
        input logic [DEF_BO_W-1:0] val
    );
        return {val, {DEF_SCALE_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/bo_value_reg.sv
module bo_value_reg #(
    parameter int BO_W  = bo_pkg::DEF_BO_W,
    parameter int LIMIT = bo_pkg::DEF_LIMIT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            dbl,
    output logic [BO_W-1:0] q
);
    localparam logic [BO_W-1:0] LIM = BO_W'(LIMIT);
    localparam logic [BO_W-1:0] TOP = BO_W'(2 * LIMIT);

    always_ff @(posedge clk) begin
        if (rst)                   q <= BO_W'(1);
        else if (load)             q <= BO_W'(1);
        else if (dbl && q <= LIM)  q <= q << 1;
    end

    // R2
    load_one_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q == BO_W'(1));
    // R4
    dbl_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (dbl && !load && q <= LIM) |=> q == ($past(q) << 1));
    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dbl && !load && q > LIM) |=> $stable(q));
    // R5
    cap_chk: assert property (@(posedge clk) disable iff (rst)
        q <= TOP);
endmodule

// File: rtl/bo_wait_port.sv
module bo_wait_port #(
    parameter int CNT_W = bo_pkg::DEF_BO_W + bo_pkg::DEF_SCALE_SH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             clear,
    input  logic [CNT_W-1:0] cycles_in,
    output logic             wait_req,
    output logic [CNT_W-1:0] wait_cycles
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_req    <= 1'b0;
            wait_cycles <= '0;
        end else if (clear) begin
            wait_req    <= 1'b0;
        end else if (capture) begin
            wait_req    <= 1'b1;
            wait_cycles <= cycles_in;
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_req && !clear) |=> (wait_req && $stable(wait_cycles)));
    // R7
    no_recapture_chk: assert property (@(posedge clk) disable iff (rst)
        capture |-> !wait_req);
endmodule

// File: rtl/bo_seq.sv
module bo_seq #(
    parameter bit SINGLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic op_start,
    input  logic op_fail,
    input  logic op_success,
    input  logic wait_done,
    output logic load,
    output logic dbl,
    output logic clear,
    output logic retry_go
);
    import bo_pkg::*;

    bo_state_e st, st_nx;
    logic      fail_acc;
    logic      done_acc;

    assign load     = op_start;
    assign fail_acc = (st == ST_ACTIVE) && op_fail && !op_start && !op_success;
    assign done_acc = (st == ST_WAIT) && wait_done && !op_start;
    assign dbl      = fail_acc && !SINGLE;
    assign clear    = op_start || done_acc;

    always_comb begin
        st_nx = st;
        if (op_start) begin
            st_nx = ST_ACTIVE;
        end else begin
            case (st)
                ST_ACTIVE: begin
                    if (op_success)             st_nx = ST_IDLE;
                    else if (fail_acc && !SINGLE) st_nx = ST_WAIT;
                end
                ST_WAIT:   if (wait_done)       st_nx = ST_ACTIVE;
                default:                        st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            retry_go <= 1'b0;
        end else begin
            st       <= st_nx;
            retry_go <= done_acc || (SINGLE && fail_acc);
        end
    end

    // R6
    go_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        done_acc |=> (retry_go && st == ST_ACTIVE));
    // R8
    idle_after_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE && op_success && !op_start) |=> st == ST_IDLE);
endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl #(
    parameter int BO_W     = bo_pkg::DEF_BO_W,
    parameter int SCALE_SH = bo_pkg::DEF_SCALE_SH,
    parameter int LIMIT    = bo_pkg::DEF_LIMIT,
    parameter bit SINGLE   = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_start,
    input  logic                     op_fail,
    input  logic                     op_success,
    input  logic                     wait_done,
    output logic                     wait_req,
    output logic [BO_W+SCALE_SH-1:0] wait_cycles,
    output logic                     retry_go,
    output logic [BO_W-1:0]          backoff_val
);
    localparam int CNT_W = BO_W + SCALE_SH;

    logic             load, dbl, clear;
    logic [CNT_W-1:0] scaled;

    assign scaled = {backoff_val, {SCALE_SH{1'b0}}};

    bo_seq #(.SINGLE(SINGLE)) u_seq (
        .clk(clk), .rst(rst), .op_start(op_start), .op_fail(op_fail),
        .op_success(op_success), .wait_done(wait_done),
        .load(load), .dbl(dbl), .clear(clear), .retry_go(retry_go)
    );

    bo_value_reg #(.BO_W(BO_W), .LIMIT(LIMIT)) u_val (
        .clk(clk), .rst(rst), .load(load), .dbl(dbl), .q(backoff_val)
    );

    bo_wait_port #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst(rst), .capture(dbl), .clear(clear),
        .cycles_in(scaled), .wait_req(wait_req), .wait_cycles(wait_cycles)
    );

    generate
        if (SINGLE) begin : g_single
            // R9
            no_wait_chk: assert property (@(posedge clk) disable iff (rst)
                !wait_req);
        end else begin : g_multi
            // R3
            req_count_chk: assert property (@(posedge clk) disable iff (rst)
                (dbl && !clear) |=> (wait_req && wait_cycles == $past(scaled)));
        end
    endgenerate
endmodule

// File: tb/test_backoff_retry_ctrl.sv
module test_backoff_retry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 0, op_fail = 0, op_success = 0, wait_done = 0;
    logic        wait_req, retry_go, s_wait_req, s_retry_go;
    logic [20:0] wait_cycles, s_wait_cycles;
    logic [13:0] backoff_val, s_backoff_val;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    backoff_retry_ctrl i_backoff_retry_ctrl (
        .clk(clk), .rst(rst), .op_start(op_start), .op_fail(op_fail),
        .op_success(op_success), .wait_done(wait_done),
        .wait_req(wait_req), .wait_cycles(wait_cycles),
        .retry_go(retry_go), .backoff_val(backoff_val)
    );

    backoff_retry_ctrl #(.SINGLE(1'b1)) i_backoff_retry_ctrl_single (
        .clk(clk), .rst(rst), .op_start(op_start), .op_fail(op_fail),
        .op_success(op_success), .wait_done(wait_done),
        .wait_req(s_wait_req), .wait_cycles(s_wait_cycles),
        .retry_go(s_retry_go), .backoff_val(s_backoff_val)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one input high for one clock; returns at the next falling edge
    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 wait_req", wait_req, 0);
        chk("R1 retry_go", retry_go, 0);
        chk("R1 backoff_val", backoff_val, 1);
    endtask

    task automatic t_single_cycle;
        pulse(op_start);
        chk("R2 backoff after start", backoff_val, 1);
        pulse(op_fail);
        chk("R3 wait_req", wait_req, 1);
        chk("R3 wait_cycles", wait_cycles, 128);
        chk("R4 doubled", backoff_val, 2);
        @(negedge clk);
        chk("R3 request held", wait_req, 1);
        chk("R6 no early go", retry_go, 0);
        pulse(wait_done);
        chk("R6 wait_req cleared", wait_req, 0);
        chk("R6 retry_go pulse", retry_go, 1);
        @(negedge clk);
        chk("R6 retry_go one cycle", retry_go, 0);
    endtask

    task automatic t_saturate;
        longint model = 1;
        pulse(op_start);
        for (int i = 0; i < 15; i++) begin
            pulse(op_fail);
            chk("R3 wait_cycles step", wait_cycles, model * 128);
            if (model <= 4096) model = model * 2;
            chk(model > 4096 ? "R5 saturated value" : "R4 doubled value",
                backoff_val, model);
            pulse(wait_done);
            chk("R6 retry_go step", retry_go, 1);
        end
        chk("R5 top value", backoff_val, 8192);
        chk("R5 top count", wait_cycles, 1048576);
    endtask

    task automatic t_ignore_fail;
        pulse(op_start);
        pulse(op_fail);
        pulse(op_fail);
        pulse(op_fail);
        chk("R7 value unchanged", backoff_val, 2);
        chk("R7 request kept", wait_req, 1);
        chk("R7 count unchanged", wait_cycles, 128);
        pulse(wait_done);
        pulse(op_fail);
        chk("R7 next count", wait_cycles, 256);
        chk("R7 next value", backoff_val, 4);
    endtask

    task automatic t_restart;
        // op_start while waiting withdraws the wait and reloads one
        pulse(op_start);
        chk("R2 reload in wait", backoff_val, 1);
        chk("R2 request withdrawn", wait_req, 0);
        pulse(op_fail);
        chk("R2 count after reload", wait_cycles, 128);
        pulse(wait_done);
    endtask

    task automatic t_success;
        pulse(op_success);
        pulse(op_fail);
        chk("R8 no wait in idle", wait_req, 0);
        chk("R8 value kept in idle", backoff_val, 2);
        chk("R8 no go in idle", retry_go, 0);
        pulse(op_start);
        chk("R8 start reloads", backoff_val, 1);
    endtask

    task automatic t_single_strand;
        pulse(op_start);
        @(negedge clk); op_fail = 1'b1;
        @(negedge clk); op_fail = 1'b0;
        chk("R9 immediate go", s_retry_go, 1);
        chk("R9 no wait_req", s_wait_req, 0);
        chk("R9 value stays", s_backoff_val, 1);
        // main copy waits instead
        chk("R9 reference copy waits", wait_req, 1);
        @(negedge clk);
        chk("R9 go one cycle", s_retry_go, 0);
        pulse(wait_done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_cycle();
        t_saturate();
        t_ignore_fail();
        pulse(op_fail);
        chk("R3 before restart", wait_req, 1);
        t_restart();
        t_success();
        t_single_strand();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule